// File: doc/BRIEF.md
# Dual-Synthesizer Serial Programming Port

This block is the configuration front end for a pair of frequency synthesizers. Software or a host controller sends a 22-bit word over three wires: a data line, a serial clock and a load strobe. The word is shifted into a frame register, one bit for each rising serial-clock edge. A rising load strobe then copies the payload into one of four holding registers. Each synthesizer has a reference word and a counter word. Two routing bits at the front of the frame choose the target. Synthesizer 1 is the high-frequency loop and occupies slot 0 of every two-slot output bus. Synthesizer 2 occupies slot 1.

The holding registers drive the divider and loop-control fields as static outputs:

- reference divide R, phase sense, charge-pump current select, charge-pump high-impedance, lock-detect select and frequency-out select;
- swallow count A, main count B, prescaler modulus and power-down.

A monitor-channel flag records which synthesizer last received a reference word. All three serial pins are taken to be synchronous to `clk` already. Their rising edges are found by comparing each pin with its value one clock earlier.

Top module: `sp_prog_if`

## Requirements
- R1: On each `clk` edge where `ser_clk` is high and was low one clock earlier, the frame register shifts by one place and takes `ser_data` in. The first bit sent ends up as the frame's top bit. A `ser_clk` that stays high, including after a load, causes no further shift.
- R2: A load happens only on a `clk` edge where `ser_le` is high and was low one clock earlier, and its fields are visible after that edge. Holding registers keep their value at all other times, including while `ser_le` stays high during later shifting.
- R3: The first two bits sent form the routing code, first bit as the code's upper bit. Code 00 selects the synthesizer 2 reference word, 01 the synthesizer 1 reference word, 10 the synthesizer 2 counter word and 11 the synthesizer 1 counter word. A load leaves the other three holding registers unchanged.
- R4: Reference frame layout after the code, in send order: 15 R bits, least significant first, then phase sense (`phase_pos`), current select (`cp_hi`), high-impedance (`cp_hiz`), lock-detect select (`lock_sel`) and frequency-out select (`fout_sel`).
- R5: Counter frame layout after the code, in send order: 7 A bits least significant first, 11 B bits least significant first, then prescaler bit (`pre_hi`, 1 means 64/65 and 0 means 32/33) and power-down bit (`pwr_dn`, 1 means powered down).
- R6: `mon_ch` becomes 0 after a synthesizer 1 reference load and 1 after a synthesizer 2 reference load. Counter-word loads leave it unchanged.
- R7: Frames still shift and load while either synthesizer has `pwr_dn` set.
- R8: If a load edge and a shift edge fall on the same `clk` edge, the load takes the frame as it was before that shift, and the shift still happens.
- R9: Synchronous active-low reset clears every field and `mon_ch` to 0, except that both `cp_hiz` bits are set to 1. Both synthesizers are then powered up with high-impedance charge pumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe |
| ref_div | output | 30 | R divide per synthesizer, 15 bits per slot |
| phase_pos | output | 2 | Phase-sense select per synthesizer |
| cp_hi | output | 2 | Charge-pump high-current select |
| cp_hiz | output | 2 | Charge-pump high-impedance |
| lock_sel | output | 2 | Lock-detect select bit |
| fout_sel | output | 2 | Frequency-out select bit |
| swallow | output | 14 | A count, 7 bits per slot |
| prog_div | output | 22 | B count, 11 bits per slot |
| pre_hi | output | 2 | Prescaler modulus select |
| pwr_dn | output | 2 | Power-down per synthesizer |
| mon_ch | output | 1 | Synthesizer named by the last reference load |

## Verification
A shift and a load can land on the same `clk` edge. In that case the load must take the frame as it stood before that shift, and the shifted bit must still enter the frame. The bench sends a complete frame, then raises `ser_clk` and `ser_le` in the same cycle while presenting the first bit of a second frame. It checks that the outputs match the first frame. It then sends the remaining 21 bits and loads again, and checks that the outputs match the second frame, which proves the coincident bit was kept.

// File: rtl/sp_pkg.sv
// Shared sizes, holding-word types and frame unpacking for the serial
// programming port. Assumes the 22-bit frame with a 2-bit routing code.
package sp_pkg;
    parameter int FRAME_W = 22;
    parameter int R_W     = 15;
    parameter int A_W     = 7;
    parameter int B_W     = 11;
    parameter int PAY_W   = FRAME_W - 2;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic           fc;
        logic           ido;
        logic           ts;
        logic           ld;
        logic           fo;
    } ref_word_t;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           pre;
        logic           pd;
    } cnt_word_t;

    // Reference payload: R sent LSB first at the top, five flags at the bottom.
    function automatic ref_word_t unpack_ref(input logic [PAY_W-1:0] p);
        ref_word_t w;
        for (int i = 0; i < R_W; i++) w.r[i] = p[PAY_W-1-i];
        w.fc  = p[4];
        w.ido = p[3];
        w.ts  = p[2];
        w.ld  = p[1];
        w.fo  = p[0];
        return w;
    endfunction

    // Counter payload: A then B, each LSB first, then prescaler and power-down.
    function automatic cnt_word_t unpack_cnt(input logic [PAY_W-1:0] p);
        cnt_word_t w;
        for (int i = 0; i < A_W; i++) w.a[i] = p[PAY_W-1-i];
        for (int i = 0; i < B_W; i++) w.b[i] = p[PAY_W-1-A_W-i];
        w.pre = p[1];
        w.pd  = p[0];
        return w;
    endfunction
endpackage

// File: rtl/sp_edge.sv
// Rising-edge finder for a pin already synchronous to clk.
// Assumes the pin is high at reset release counts as not yet low, so a
// level held high produces no edge.
module sp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic pin_q;

    // Keep last cycle's pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin;
    end

    assign rise = pin & ~pin_q;
endmodule

// File: rtl/sp_shift.sv
// Serial-in frame register; the first bit shifted ends at the top bit.
// Assumes shift_en is a single-cycle strobe.
module sp_shift #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Shift one place toward the top on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/sp_chan.sv
// Holding registers of one synthesizer: reference word and counter word.
// Assumes at most one of ref_we / cnt_we is high in a cycle.
module sp_chan
    import sp_pkg::*;
#(
    parameter int P_W = sp_pkg::PAY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_we,
    input  logic           cnt_we,
    input  logic [P_W-1:0] payload,
    output ref_word_t      ref_q,
    output cnt_word_t      cnt_q
);
    // Reference word: reset clears all but the high-impedance bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= '0;
            ref_q.ts <= 1'b1;
        end else if (ref_we) begin
            ref_q <= unpack_ref(payload);
        end
    end

    // Counter word: reset leaves the synthesizer powered up.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= unpack_cnt(payload);
    end
endmodule

// File: rtl/sp_prog_if.sv
// Top of the serial programming port: edge finders, frame register,
// routing decode, two channel register sets and the monitor flag.
// Assumes serial pins are synchronous to clk; slot 0 is synthesizer 1.
module sp_prog_if #(
    parameter int FRAME_W = sp_pkg::FRAME_W,
    parameter int R_W     = sp_pkg::R_W,
    parameter int A_W     = sp_pkg::A_W,
    parameter int B_W     = sp_pkg::B_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [2*R_W-1:0] ref_div,
    output logic [1:0]       phase_pos,
    output logic [1:0]       cp_hi,
    output logic [1:0]       cp_hiz,
    output logic [1:0]       lock_sel,
    output logic [1:0]       fout_sel,
    output logic [2*A_W-1:0] swallow,
    output logic [2*B_W-1:0] prog_div,
    output logic [1:0]       pre_hi,
    output logic [1:0]       pwr_dn,
    output logic             mon_ch
);
    localparam int CH_N  = 2;
    localparam int PAY_W = FRAME_W - 2;

    logic               clk_rise;
    logic               le_rise;
    logic [FRAME_W-1:0] sr_q;
    logic [1:0]         code;
    logic [PAY_W-1:0]   payload;
    logic [CH_N-1:0]    ref_we;
    logic [CH_N-1:0]    cnt_we;
    sp_pkg::ref_word_t  ref_q [CH_N];
    sp_pkg::cnt_word_t  cnt_q [CH_N];

    sp_edge u_clk_edge (.clk(clk), .rst_n(rst_n), .pin(ser_clk), .rise(clk_rise));
    sp_edge u_le_edge  (.clk(clk), .rst_n(rst_n), .pin(ser_le),  .rise(le_rise));

    sp_shift #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .din(ser_data), .q(sr_q)
    );

    assign code    = sr_q[FRAME_W-1 -: 2];
    assign payload = sr_q[PAY_W-1:0];

    generate
        for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
            // code[0]=1 targets slot 0, code[1] picks counter over reference.
            assign ref_we[ch] = le_rise & ~code[1] & (code[0] == (ch == 0));
            assign cnt_we[ch] = le_rise &  code[1] & (code[0] == (ch == 0));

            sp_chan #(.P_W(PAY_W)) u_chan (
                .clk(clk), .rst_n(rst_n), .ref_we(ref_we[ch]), .cnt_we(cnt_we[ch]),
                .payload(payload), .ref_q(ref_q[ch]), .cnt_q(cnt_q[ch])
            );

            assign ref_div[ch*R_W +: R_W]  = ref_q[ch].r;
            assign phase_pos[ch]           = ref_q[ch].fc;
            assign cp_hi[ch]               = ref_q[ch].ido;
            assign cp_hiz[ch]              = ref_q[ch].ts;
            assign lock_sel[ch]            = ref_q[ch].ld;
            assign fout_sel[ch]            = ref_q[ch].fo;
            assign swallow[ch*A_W +: A_W]  = cnt_q[ch].a;
            assign prog_div[ch*B_W +: B_W] = cnt_q[ch].b;
            assign pre_hi[ch]              = cnt_q[ch].pre;
            assign pwr_dn[ch]              = cnt_q[ch].pd;
        end
    endgenerate

    // Monitor flag follows the slot of the last reference load.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mon_ch <= 1'b0;
        else if (le_rise & ~code[1]) mon_ch <= ~code[0];
    end
endmodule

// File: rtl/sp_prog_if_chk.sv
// Property checker for sp_prog_if, attached by bind below. Observes the
// serial pins, the frame register and the holding outputs.
module sp_prog_if_chk #(
    parameter int FRAME_W = 22,
    parameter int R_W     = 15,
    parameter int A_W     = 7,
    parameter int B_W     = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_clk,
    input logic               ser_data,
    input logic               ser_le,
    input logic [FRAME_W-1:0] sr_q,
    input logic [2*R_W-1:0]   ref_div,
    input logic [1:0]         phase_pos,
    input logic [1:0]         cp_hi,
    input logic [1:0]         cp_hiz,
    input logic [1:0]         lock_sel,
    input logic [1:0]         fout_sel,
    input logic [2*A_W-1:0]   swallow,
    input logic [2*B_W-1:0]   prog_div,
    input logic [1:0]         pre_hi,
    input logic [1:0]         pwr_dn,
    input logic               mon_ch
);
    localparam int OUT_W = 2*(R_W + A_W + B_W + 7) + 1;
    localparam int CH1_W = R_W + A_W + B_W + 7;

    logic             sck_q_c, le_q_c, sck_rise_c, le_rise_c;
    logic [OUT_W-1:0] outs;
    logic [CH1_W-1:0] ch1_outs;

    // Checker's own copies of the pin history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q_c <= 1'b1;
            le_q_c  <= 1'b1;
        end else begin
            sck_q_c <= ser_clk;
            le_q_c  <= ser_le;
        end
    end

    assign sck_rise_c = ser_clk & ~sck_q_c;
    assign le_rise_c  = ser_le & ~le_q_c;
    assign outs = {ref_div, phase_pos, cp_hi, cp_hiz, lock_sel, fout_sel,
                   swallow, prog_div, pre_hi, pwr_dn, mon_ch};
    assign ch1_outs = {ref_div[2*R_W-1:R_W], swallow[2*A_W-1:A_W], prog_div[2*B_W-1:B_W],
                       phase_pos[1], cp_hi[1], cp_hiz[1], lock_sel[1], fout_sel[1],
                       pre_hi[1], pwr_dn[1]};

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise_c |=> sr_q == {$past(sr_q[FRAME_W-2:0]), $past(ser_data)}); // R1
    AST_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise_c |=> $stable(sr_q)); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise_c |=> $stable(outs)); // R2
    AST_OTHER_CH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise_c && sr_q[FRAME_W-2]) |=> $stable(ch1_outs)); // R3
    AST_MON_CNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise_c && sr_q[FRAME_W-1]) |=> $stable(mon_ch)); // R6
    AST_MON_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise_c && !sr_q[FRAME_W-1]) |=> mon_ch == !$past(sr_q[FRAME_W-2])); // R6
    AST_PD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise_c && pwr_dn[0] && sr_q[FRAME_W-1 -: 2] == 2'b01)
        |=> ref_div[R_W-1:0] == $past(sp_pkg::unpack_ref(sr_q[FRAME_W-3:0]).r)); // R7
endmodule

bind sp_prog_if sp_prog_if_chk #(
    .FRAME_W(FRAME_W), .R_W(R_W), .A_W(A_W), .B_W(B_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .sr_q(sr_q), .ref_div(ref_div), .phase_pos(phase_pos), .cp_hi(cp_hi),
    .cp_hiz(cp_hiz), .lock_sel(lock_sel), .fout_sel(fout_sel), .swallow(swallow),
    .prog_div(prog_div), .pre_hi(pre_hi), .pwr_dn(pwr_dn), .mon_ch(mon_ch)
);

// File: tb/sp_prog_if_test.sv
`timescale 1ns/1ps
module sp_prog_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [29:0] ref_div;
    logic [1:0]  phase_pos, cp_hi, cp_hiz, lock_sel, fout_sel, pre_hi, pwr_dn;
    logic [13:0] swallow;
    logic [21:0] prog_div;
    logic        mon_ch;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    logic [14:0] e_r [2];
    logic [4:0]  e_f [2];
    logic [6:0]  e_a [2];
    logic [10:0] e_b [2];
    logic        e_pre [2];
    logic        e_pd [2];
    logic        e_mon;

    always #2.5 clk = ~clk;

    sp_prog_if uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_div(ref_div), .phase_pos(phase_pos), .cp_hi(cp_hi), .cp_hiz(cp_hiz),
        .lock_sel(lock_sel), .fout_sel(fout_sel), .swallow(swallow), .prog_div(prog_div),
        .pre_hi(pre_hi), .pwr_dn(pwr_dn), .mon_ch(mon_ch)
    );

    // Vector: {code[1:0], R or A[14:0], B[10:0], flags[4:0]}.
    // Reference flags {phase, cp_hi, hiz, lock, fout}; counter flags {.., pre, pd}.
    localparam logic [32:0] VEC [7] = '{
        {2'b01, 15'd12345, 11'd0,    5'b10110},
        {2'b00, 15'd3,     11'd0,    5'b01001},
        {2'b11, 15'd63,    11'd2047, 5'b00011},
        {2'b10, 15'd5,     11'd3,    5'b00010},
        {2'b01, 15'd32767, 11'd0,    5'b11111},
        {2'b11, 15'd0,     11'd1000, 5'b00000},
        {2'b00, 15'd21845, 11'd0,    5'b10100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Frame in send order: index 21 goes first.
    function automatic logic [21:0] build(input logic [32:0] v);
        logic [21:0] fr;
        logic [1:0]  code = v[32:31];
        fr = '0;
        fr[21] = code[1];
        fr[20] = code[0];
        if (!code[1]) begin
            for (int i = 0; i < 15; i++) fr[19-i] = v[16+i];
            fr[4:0] = v[4:0];
        end else begin
            for (int i = 0; i < 7; i++)  fr[19-i] = v[16+i];
            for (int i = 0; i < 11; i++) fr[12-i] = v[5+i];
            fr[1:0] = v[1:0];
        end
        return fr;
    endfunction

    function automatic void apply(input logic [32:0] v);
        int ch = v[31] ? 0 : 1;
        if (!v[32]) begin
            e_r[ch] = v[30:16];
            e_f[ch] = v[4:0];
            e_mon   = (ch == 1);
        end else begin
            e_a[ch]   = v[22:16];
            e_b[ch]   = v[15:5];
            e_pre[ch] = v[1];
            e_pd[ch]  = v[0];
        end
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R3 R4 ref_div"}, 32'(ref_div), 32'({e_r[1], e_r[0]}));
        chk({tag, " R4 flags"}, 32'({phase_pos, cp_hi, cp_hiz, lock_sel, fout_sel}),
            32'({e_f[1][4], e_f[0][4], e_f[1][3], e_f[0][3], e_f[1][2], e_f[0][2],
                 e_f[1][1], e_f[0][1], e_f[1][0], e_f[0][0]}));
        chk({tag, " R5 swallow/pre/pd"}, 32'({swallow, pre_hi, pwr_dn}),
            32'({e_a[1], e_a[0], e_pre[1], e_pre[0], e_pd[1], e_pd[0]}));
        chk({tag, " R5 prog_div"}, 32'(prog_div), 32'({e_b[1], e_b[0]}));
        chk({tag, " R6 mon_ch"}, 32'(mon_ch), 32'(e_mon));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b0;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input logic [21:0] fr);
        for (int i = 21; i >= 0; i--) send_bit(fr[i]);
    endtask

    task automatic pulse_le();
        @(negedge clk);
        ser_le = 1'b1;
        repeat (3) @(negedge clk);
        ser_le = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [21:0] fa, fb;
        for (int c = 0; c < 2; c++) begin
            e_r[c] = '0; e_f[c] = 5'b00100; e_a[c] = '0; e_b[c] = '0;
            e_pre[c] = 1'b0; e_pd[c] = 1'b0;
        end
        e_mon = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: reset state
        check_all("R9 reset");

        // Table walk: R3, R4, R5, R6, R7
        for (int k = 0; k < 7; k++) begin
            send_frame(build(VEC[k]));
            pulse_le();
            apply(VEC[k]);
            check_all($sformatf("vec%0d", k));
            if (k == 4) chk("R7 load with pwr_dn set", 32'(ref_div[14:0]), 32'd32767);
        end

        // R1: serial clock left high long after the last bit, then load
        fa = build({2'b10, 15'd100, 11'd1234, 5'b00001});
        send_frame(fa);
        repeat (40) @(negedge clk);
        pulse_le();
        apply({2'b10, 15'd100, 11'd1234, 5'b00001});
        check_all("R1 held-high clk");
        pulse_le();
        check_all("R1 no shift on reload");

        // R2: strobe held high while a new frame shifts in
        @(negedge clk);
        ser_le = 1'b1;
        repeat (3) @(negedge clk);
        send_frame(build({2'b01, 15'd777, 11'd0, 5'b00000}));
        check_all("R2 le held high");
        ser_le = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R2 le falling edge");
        pulse_le();
        apply({2'b01, 15'd777, 11'd0, 5'b00000});
        check_all("R2 fresh edge");

        // R8: coincident load and shift edges
        fa = build({2'b00, 15'd4095, 11'd0, 5'b11000});
        fb = build({2'b11, 15'd42,   11'd513, 5'b00010});
        send_frame(fa);
        @(negedge clk);
        ser_data = fb[21];
        ser_clk  = 1'b0;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        ser_le  = 1'b1;
        repeat (3) @(negedge clk);
        apply({2'b00, 15'd4095, 11'd0, 5'b11000});
        check_all("R8 load takes pre-shift frame");
        ser_le = 1'b0;
        for (int i = 20; i >= 0; i--) send_bit(fb[i]);
        pulse_le();
        apply({2'b11, 15'd42, 11'd513, 5'b00010});
        check_all("R8 coincident bit kept");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule